// File: doc/BRIEF.md
# Dual-Nibble Absorb Unit

This block folds one input byte per clock into a permutation held in a flip-flop bank of N entries, where N is a power of two (256 by default). It also owns the absorb counter. The byte is split into two nibbles, low first. Each nibble exchanges the entry at the counter with the entry at `N/2 + nibble` (modulo N), and then the counter advances by one. Both exchanges of a byte are merged into a single cycle. The four addresses involved can coincide in several ways. Three equality tests classify them, and the class selects a small table of register transfers, so the merged result always matches the two exchanges done one after the other.

When the counter reaches the halfway point, the surrounding engine has to run its mixing pass. The unit models that pass only as a handshake. It raises `shuffle_req` and drops `ready`, and it waits for a one-cycle `resume` strobe. The strobe means the counter has been cleared by the mixing pass. Any nibble that was still waiting is then absorbed starting from counter value zero. A load input lets the controlling engine place the counter at any value up to `N/2`, as other absorb steps of that engine do.

Top module: `nibble_absorb_unit`

## Requirements
- R1: After reset, entry e of the bank holds the value e and `count` is 0. `ready` is 1 and `shuffle_req` is 0.
- R2: An accepted byte (`byte_valid` high while `ready` is high and `cnt_load` low) with `count < N/2-1` does the following by the next clock edge. It exchanges S[count] with S[(N/2 + byte[3:0]) mod N], then exchanges S[count+1] with S[(N/2 + byte[7:4]) mod N]. It adds 2 to `count`.
- R3: The R2 result holds for every coincidence among the four addresses, including the case where the low-nibble slot equals count+1 and the high-nibble slot equals count. In that case the bank is left unchanged.
- R4: A byte accepted with `count == N/2` leaves the bank and `count` unchanged. It makes `shuffle_req` 1 and `ready` 0 after that edge, and the byte is held.
- R5: A byte accepted with `count == N/2-1` performs only the low-nibble exchange. It sets `count` to N/2, makes `shuffle_req` 1 and holds the high nibble.
- R6: A `resume` while a high nibble is held treats the counter as cleared. It exchanges S[0] with S[(N/2 + high) mod N], sets `count` to 1 and returns `ready` to 1.
- R7: A `resume` while a whole byte is held performs the R2 exchange pair from counter 0. It sets `count` to 2 and returns `ready` to 1.
- R8: While `ready` is 0, `byte_valid` has no effect on the bank, on `count` or on the held byte.
- R9: A `resume` while no request is pending has no effect.
- R10: `count` never exceeds N/2.
- R11: `cnt_load` while `ready` is 1 sets `count` to `min(cnt_value, N/2)` and leaves the bank unchanged. A byte offered in the same cycle is not absorbed, and `cnt_load` has no effect while `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | Offers `byte_data` for absorption |
| byte_data | input | 8 | Byte to absorb; bits 3:0 go first |
| resume | input | 1 | One-cycle strobe: the mixing pass is done and the counter is cleared |
| cnt_load | input | 1 | Places the counter at `cnt_value` |
| cnt_value | input | log2(N) | Counter value to load (saturated at N/2) |
| ready | output | 1 | A byte can be accepted this cycle |
| shuffle_req | output | 1 | The mixing pass is requested |
| count | output | log2(N) | Absorb counter |
| state_flat | output | N*log2(N) | Bank contents; entry e at bits [e*log2(N) +: log2(N)] |

## Verification
Two nibble exchanges land in the same cycle, and their addresses can alias. The bench is built with N=16 so that the nibble slots wrap into the lower half. At a loaded counter value it crafts bytes that hit each of the seven reachable equality classes, and it adds a self-exchange. Every result is compared with a reference that performs the two exchanges in sequence. The second pairing is the halfway request, where one byte's nibbles are split across a resume. This is provoked by loading the counter to N/2-1 and to N/2, and is judged against the same sequential reference with the counter cleared at the resume.

// File: rtl/nau_pkg.sv
package nau_pkg;

   localparam int NUM_PORTS = 4;
   localparam int P_A1 = 0;
   localparam int P_B1 = 1;
   localparam int P_A2 = 2;
   localparam int P_B2 = 3;

   // encoding = {a2==b1, b2==a1, b2==b1}
   typedef enum logic [2:0] {
      XC_DISTINCT      = 3'b000,
      XC_B_SHARED      = 3'b001,
      XC_HI_ON_A1      = 3'b010,
      XC_HI_A1_SHARED  = 3'b011,
      XC_LO_ON_A2      = 3'b100,
      XC_LO_A2_SHARED  = 3'b101,
      XC_IDENTITY      = 3'b110,
      XC_NEVER         = 3'b111
   } xfer_class_e;

   typedef enum logic [1:0] {
      OP_IDLE   = 2'd0,
      OP_SINGLE = 2'd1,
      OP_DOUBLE = 2'd2
   } op_e;

   typedef enum logic [1:0] {
      ST_RUN       = 2'd0,
      ST_WAIT_HIGH = 2'd1,
      ST_WAIT_BYTE = 2'd2
   } st_e;

   typedef struct packed {
      logic       en;
      logic [1:0] src;
   } wport_t;

endpackage

// File: rtl/nau_addr_gen.sv
module nau_addr_gen
   import nau_pkg::*;
#(
   parameter int N = 256
) (
   input  logic [$clog2(N)-1:0]                 base,
   input  logic [3:0]                           nib_first,
   input  logic [3:0]                           nib_second,
   output logic [NUM_PORTS-1:0][$clog2(N)-1:0]  addr,
   output xfer_class_e                          cls
);
   localparam int W    = $clog2(N);
   localparam int HALF = N / 2;

   logic [W-1:0] slot_first;
   logic [W-1:0] slot_second;
   logic         lo_on_a2;
   logic         hi_on_a1;
   logic         slots_shared;

   generate
      if (N >= 32) begin : g_no_wrap
         // nibble fits below HALF: the upper slot is a plain OR
         assign slot_first  = W'(HALF) | W'(nib_first);
         assign slot_second = W'(HALF) | W'(nib_second);
      end else begin : g_wrap
         // small arrays: the slot wraps into the lower half
         assign slot_first  = W'(32'(HALF) + 32'(nib_first));
         assign slot_second = W'(32'(HALF) + 32'(nib_second));
      end
   endgenerate

   assign addr[P_A1] = base;
   assign addr[P_B1] = slot_first;
   assign addr[P_A2] = base + W'(1);
   assign addr[P_B2] = slot_second;

   assign lo_on_a2     = (addr[P_A2] == addr[P_B1]);
   assign hi_on_a1     = (addr[P_B2] == addr[P_A1]);
   assign slots_shared = (addr[P_B2] == addr[P_B1]);

   assign cls = xfer_class_e'({lo_on_a2, hi_on_a1, slots_shared});

endmodule

// File: rtl/nau_xfer_table.sv
module nau_xfer_table
   import nau_pkg::*;
(
   input  op_e                        op,
   input  xfer_class_e                cls,
   output wport_t [NUM_PORTS-1:0]     wp
);

   function automatic wport_t take(input int src);
      wport_t r;
      r.en  = 1'b1;
      r.src = 2'(src);
      return r;
   endfunction

   always_comb begin
      for (int p = 0; p < NUM_PORTS; p++) begin
         wp[p] = '0;
      end
      unique case (op)
         OP_SINGLE: begin
            wp[P_A1] = take(P_B1);
            wp[P_B1] = take(P_A1);
         end
         OP_DOUBLE: begin
            unique case (cls)
               XC_DISTINCT: begin
                  wp[P_A1] = take(P_B1);
                  wp[P_B1] = take(P_A1);
                  wp[P_A2] = take(P_B2);
                  wp[P_B2] = take(P_A2);
               end
               XC_B_SHARED: begin
                  wp[P_A2] = take(P_A1);
                  wp[P_B1] = take(P_A2);
                  wp[P_A1] = take(P_B1);
               end
               XC_HI_ON_A1: begin
                  wp[P_B1] = take(P_A1);
                  wp[P_A1] = take(P_A2);
                  wp[P_A2] = take(P_B1);
               end
               XC_HI_A1_SHARED: begin
                  wp[P_A2] = take(P_A1);
                  wp[P_A1] = take(P_A2);
               end
               XC_LO_ON_A2: begin
                  wp[P_B2] = take(P_A1);
                  wp[P_B1] = take(P_B2);
                  wp[P_A1] = take(P_B1);
               end
               XC_LO_A2_SHARED: begin
                  wp[P_B1] = take(P_A1);
                  wp[P_A1] = take(P_B1);
               end
               XC_IDENTITY: begin
               end
               default: begin
               end
            endcase
         end
         default: begin
         end
      endcase
   end

   // R3: the three-way coincidence is unreachable because a2 = a1 + 1
   always_comb begin
      if (op == OP_DOUBLE) begin
         a_r3_no_triple_alias: assert (cls != XC_NEVER);
      end
   end

endmodule

// File: rtl/nau_state_bank.sv
module nau_state_bank
   import nau_pkg::*;
#(
   parameter int N = 256
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_PORTS-1:0][$clog2(N)-1:0] addr,
   input  wport_t [NUM_PORTS-1:0]              wp,
   output logic [N*$clog2(N)-1:0]              state_flat
);
   localparam int W = $clog2(N);

   logic [N-1:0][W-1:0]         mem_q;
   logic [NUM_PORTS-1:0][W-1:0] rd;
   logic [NUM_PORTS-1:0][W-1:0] wdata;

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         assign rd[p]    = mem_q[addr[p]];
         assign wdata[p] = rd[wp[p].src];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < N; e++) begin
            mem_q[e] <= W'(e);
         end
      end else begin
         for (int e = 0; e < N; e++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
               if (wp[p].en && (addr[p] == W'(e))) begin
                  mem_q[e] <= wdata[p];
               end
            end
         end
      end
   end

   assign state_flat = mem_q;

   // R3: two write ports aimed at one entry must carry the same value
   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pa
         for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pb
            a_r3_port_agree: assert property (@(posedge clk) disable iff (!rst_n)
               (wp[p].en && wp[q].en && (addr[p] == addr[q])) |-> (wdata[p] == wdata[q]));
         end
      end
   endgenerate

endmodule

// File: rtl/nibble_absorb_unit.sv
module nibble_absorb_unit
   import nau_pkg::*;
#(
   parameter int N = 256
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      byte_valid,
   input  logic [7:0]                byte_data,
   input  logic                      resume,
   input  logic                      cnt_load,
   input  logic [$clog2(N)-1:0]      cnt_value,
   output logic                      ready,
   output logic                      shuffle_req,
   output logic [$clog2(N)-1:0]      count,
   output logic [N*$clog2(N)-1:0]    state_flat
);
   localparam int W = $clog2(N);
   localparam logic [W-1:0] HALF_V = W'(N / 2);

   generate
      if ((N < 4) || ((N & (N - 1)) != 0)) begin : g_bad_n
         $error("nibble_absorb_unit: N must be a power of two of at least 4");
      end
   endgenerate

   st_e          st_q, st_d;
   logic [W-1:0] count_q, count_d;
   logic [7:0]   held_q, held_d;
   logic [W-1:0] base;
   logic [3:0]   nib_first, nib_second;
   op_e          op;
   logic         at_half, near_half, accept;
   logic [W-1:0] load_sat;

   logic [NUM_PORTS-1:0][W-1:0] addr;
   xfer_class_e                 cls;
   wport_t [NUM_PORTS-1:0]      wp;

   assign at_half   = (count_q == HALF_V);
   assign near_half = (count_q == HALF_V - W'(1));
   assign accept    = byte_valid && (st_q == ST_RUN) && !cnt_load;
   assign load_sat  = (cnt_value > HALF_V) ? HALF_V : cnt_value;

   always_comb begin
      st_d       = st_q;
      count_d    = count_q;
      held_d     = held_q;
      base       = count_q;
      nib_first  = byte_data[3:0];
      nib_second = byte_data[7:4];
      op         = OP_IDLE;
      unique case (st_q)
         ST_RUN: begin
            if (cnt_load) begin
               count_d = load_sat;
            end else if (byte_valid) begin
               held_d = byte_data;
               if (at_half) begin
                  st_d = ST_WAIT_BYTE;
               end else if (near_half) begin
                  op      = OP_SINGLE;
                  count_d = count_q + W'(1);
                  st_d    = ST_WAIT_HIGH;
               end else begin
                  op      = OP_DOUBLE;
                  count_d = count_q + W'(2);
               end
            end
         end
         ST_WAIT_HIGH: begin
            nib_first = held_q[7:4];
            if (resume) begin
               base    = '0;
               op      = OP_SINGLE;
               count_d = W'(1);
               st_d    = ST_RUN;
            end
         end
         ST_WAIT_BYTE: begin
            nib_first  = held_q[3:0];
            nib_second = held_q[7:4];
            if (resume) begin
               base    = '0;
               op      = OP_DOUBLE;
               count_d = W'(2);
               st_d    = ST_RUN;
            end
         end
         default: begin
            st_d = ST_RUN;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_RUN;
         count_q <= '0;
         held_q  <= '0;
      end else begin
         st_q    <= st_d;
         count_q <= count_d;
         held_q  <= held_d;
      end
   end

   nau_addr_gen #(.N(N)) u_addr (
      .base       (base),
      .nib_first  (nib_first),
      .nib_second (nib_second),
      .addr       (addr),
      .cls        (cls)
   );

   nau_xfer_table u_table (
      .op  (op),
      .cls (cls),
      .wp  (wp)
   );

   nau_state_bank #(.N(N)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (addr),
      .wp         (wp),
      .state_flat (state_flat)
   );

   assign ready       = (st_q == ST_RUN);
   assign shuffle_req = (st_q != ST_RUN);
   assign count       = count_q;

   // R2: a plain double absorb advances the counter by two
   a_r2_double_step: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !at_half && !near_half) |=> (count == $past(count) + W'(2)));

   // R4: a byte at the halfway point only raises the request
   a_r4_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && at_half) |=> (shuffle_req && !ready && $stable(state_flat) && $stable(count)));

   // R5: one nibble before the halfway point
   a_r5_near_half: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && near_half) |=> (shuffle_req && (count == HALF_V)));

   // R6: resume with a held high nibble
   a_r6_resume_high: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_WAIT_HIGH) && resume) |=> (ready && (count == W'(1))));

   // R7: resume with a held whole byte
   a_r7_resume_byte: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_WAIT_BYTE) && resume) |=> (ready && (count == W'(2))));

   // R8: nothing moves while waiting for the resume strobe
   a_r8_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !resume) |=> ($stable(state_flat) && $stable(count) && shuffle_req));

   // R9: a stray resume is ignored
   a_r9_stray_resume: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && resume && !byte_valid && !cnt_load) |=> ($stable(state_flat) && $stable(count)));

   // R10: the counter stays within the lower half plus one
   a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= HALF_V);

   // R11: a load moves only the counter
   a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && cnt_load) |=> ($stable(state_flat) &&
         (count == (($past(cnt_value) > HALF_V) ? HALF_V : $past(cnt_value)))));

endmodule

// File: tb/tb_nibble_absorb_unit.sv
module tb_nibble_absorb_unit;
   localparam int TB_N = 16;
   localparam int W    = $clog2(TB_N);
   localparam int HALF = TB_N / 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              byte_valid = 1'b0;
   logic [7:0]        byte_data = '0;
   logic              resume = 1'b0;
   logic              cnt_load = 1'b0;
   logic [W-1:0]      cnt_value = '0;
   logic              ready;
   logic              shuffle_req;
   logic [W-1:0]      count;
   logic [TB_N*W-1:0] state_flat;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   int ref_s [TB_N];
   int ref_a;
   int ref_pend;      // 0 none, 1 high nibble held, 2 whole byte held
   int ref_byte;

   nibble_absorb_unit #(.N(TB_N)) dut (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
      .resume(resume), .cnt_load(cnt_load), .cnt_value(cnt_value),
      .ready(ready), .shuffle_req(shuffle_req), .count(count), .state_flat(state_flat)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int e = 0; e < TB_N; e++) begin
         chk(req, $sformatf("S[%0d]", e), int'(state_flat[e*W +: W]), ref_s[e]);
      end
      chk(req, "count", int'(count), ref_a);
      chk(req, "ready", int'(ready), (ref_pend == 0) ? 1 : 0);
      chk(req, "shuffle_req", int'(shuffle_req), (ref_pend != 0) ? 1 : 0);
   endtask

   task automatic ref_swap(input int p, input int q);
      int t;
      t = ref_s[p]; ref_s[p] = ref_s[q]; ref_s[q] = t;
   endtask

   task automatic ref_nib(input int x);
      ref_swap(ref_a, (HALF + x) % TB_N);
      ref_a++;
   endtask

   function automatic int nib_for(input int slot);
      return (slot - HALF + 2 * TB_N) % TB_N;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; byte_valid = 1'b0; resume = 1'b0; cnt_load = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int e = 0; e < TB_N; e++) ref_s[e] = e;
      ref_a = 0; ref_pend = 0; ref_byte = 0;
   endtask

   task automatic absorb(input logic [7:0] b, input string req);
      @(negedge clk);
      byte_valid = 1'b1; byte_data = b;
      @(negedge clk);
      byte_valid = 1'b0;
      if (ref_pend == 0) begin
         if (ref_a == HALF) begin
            ref_pend = 2; ref_byte = int'(b);
         end else if (ref_a == HALF - 1) begin
            ref_nib(int'(b[3:0]));
            ref_pend = 1; ref_byte = int'(b);
         end else begin
            ref_nib(int'(b[3:0]));
            ref_nib(int'(b[7:4]));
         end
      end
      check_all(req);
   endtask

   task automatic do_resume(input string req);
      @(negedge clk);
      resume = 1'b1;
      @(negedge clk);
      resume = 1'b0;
      if (ref_pend == 1) begin
         ref_a = 0; ref_nib((ref_byte >> 4) & 15);
      end else if (ref_pend == 2) begin
         ref_a = 0; ref_nib(ref_byte & 15); ref_nib((ref_byte >> 4) & 15);
      end
      ref_pend = 0;
      check_all(req);
   endtask

   task automatic load_count(input int v, input string req);
      @(negedge clk);
      cnt_load = 1'b1; cnt_value = W'(v);
      @(negedge clk);
      cnt_load = 1'b0;
      if (ref_pend == 0) ref_a = (v > HALF) ? HALF : v;
      check_all(req);
   endtask

   task automatic t_reset();
      do_reset();
      check_all("R1");
   endtask

   task automatic t_plain();
      do_reset();
      for (int n = 0; n < 3; n++) absorb(8'($urandom), "R2");
   endtask

   // slot pairs (low slot offset, high slot offset) relative to the counter
   task automatic t_alias();
      int lo_off [8] = '{3, 3, 3, 0, 1, 1, 1, 0};
      int hi_off [8] = '{4, 3, 0, 0, 3, 1, 0, 1};
      for (int c = 0; c < 8; c++) begin
         int base;
         do_reset();
         absorb(8'($urandom), "R2");
         absorb(8'($urandom), "R2");
         load_count($urandom_range(HALF - 2, 0), "R11");
         base = ref_a;
         absorb({4'(nib_for(base + hi_off[c])), 4'(nib_for(base + lo_off[c]))},
                $sformatf("R3 class%0d", c));
      end
   endtask

   task automatic t_full_wait();
      do_reset();
      absorb(8'h5a, "R2");
      load_count(HALF, "R11");
      absorb(8'($urandom), "R4");
      absorb(8'($urandom), "R8");
      load_count(3, "R11 ignored while busy");
      absorb(8'($urandom), "R8");
      do_resume("R7");
      absorb(8'($urandom), "R2");
   endtask

   task automatic t_near();
      do_reset();
      absorb(8'hc3, "R2");
      load_count(HALF - 1, "R11");
      absorb(8'($urandom), "R5");
      absorb(8'($urandom), "R8");
      do_resume("R6");
      absorb(8'($urandom), "R2");
   endtask

   task automatic t_stray_and_sat();
      do_reset();
      absorb(8'h17, "R2");
      do_resume("R9");
      load_count(TB_N - 1, "R11 saturate");
      chk("R10", "count bound", int'(count), HALF);
   endtask

   task automatic t_random();
      do_reset();
      for (int it = 0; it < 300; it++) begin
         int r;
         r = $urandom % 8;
         if (ref_pend != 0) begin
            if (r < 2) absorb(8'($urandom), "R8");
            else do_resume((ref_pend == 1) ? "R6" : "R7");
         end else if (r == 0) begin
            load_count($urandom_range(HALF, 0), "R11");
         end else if (r == 1) begin
            do_resume("R9");
         end else begin
            absorb(8'($urandom), "R3");
         end
         chk("R10", "count bound", (int'(count) <= HALF) ? 1 : 0, 1);
      end
   endtask

   initial begin
      t_reset();
      t_plain();
      t_alias();
      t_full_wait();
      t_near();
      t_stray_and_sat();
      t_random();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule